// File: doc/BRIEF.md
# Deferred-Normalization Floating-Point Multiply Chain

This block multiplies a sequence of floating-point operands into one running product and does not normalize the product between steps. Each operand carries a sign, a biased exponent and a fraction with an implied leading one. The running mantissa is wider than the operand mantissa. Its low guard bits absorb the one-bit slip that each product may cause, so no precision is lost while the value stays unnormalized.

When the operand flagged as the end of a chain has been merged, the unit runs one normalization step. That step finds the leading one, shifts it to the top and corrects the exponent. The result then appears on the output for one cycle, together with the raw accumulator and exponent that existed before normalization.

A chain can hold only a fixed number of multiplies. If an operand arrives when the chain is full, the held product is normalized and emitted first, and that operand then opens a new chain.

Top module: `dnm_chain_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An operand has the value (1 + frac/2^15) * 2^(exp - 511). Its 15-bit fraction is placed under an implied one, so the 20-bit running mantissa is {1, frac, 4'b0000}.
- R3: An operand accepted while idle, or with `in_first` set, starts a new chain: the accumulator becomes that operand and the multiply count becomes 0. An operand with both `in_first` and `in_last` set comes back with its exponent and fraction unchanged.
- R4: Each later operand in a chain sets the accumulator to (acc * {1,frac}) >> 16 and the exponent to acc_exp + exp - 511 + 1, modulo 1024. No normalization takes place between these steps.
- R5: Each multiply adds at most one leading zero to the accumulator. After four multiplies of 1.0, the raw mantissa is 0x08000.
- R6: At the end of a chain the result exponent is acc_exp - lz, where lz counts the leading zeros of the 20-bit accumulator. The result fraction is bits 18..4 of the accumulator shifted left by lz, with the remaining bits truncated.
- R7: Suppose the operand carrying `in_last` is taken at clock edge k. Then `in_ready` is 0 after edge k, and `out_valid` is 1 for exactly one cycle after edge k+1, at which point `in_ready` is 1 again.
- R8: The result sign is the XOR of the signs of all operands in the chain.
- R9: A chain holds at most 4 multiplies. If an operand is presented when the chain is full, it is not taken. The held chain is normalized and emitted first, and that operand then starts a new chain.
- R10: An operand flagged `in_first` in the middle of a chain throws away the running product, and no result is produced for it.
- R11: `in_ready` is 0 only during the normalization cycle and while a full chain waits for an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_first | input | 1 | Operand opens a new chain |
| in_last | input | 1 | Operand closes the chain |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 10 | Operand biased exponent |
| in_frac | input | 15 | Operand fraction below the implied one |
| out_valid | output | 1 | One-cycle result strobe |
| out_sign | output | 1 | Result sign |
| out_exp | output | 10 | Normalized result exponent |
| out_frac | output | 15 | Normalized result fraction |
| out_raw_mant | output | 20 | Accumulator before normalization |
| out_raw_exp | output | 10 | Exponent before normalization |

## Verification
A wrong leading-zero count, or a product cut at the wrong bit, is visible within two cycles of the closing operand. It shows as an exponent off by a few units or as a shifted fraction, and the raw accumulator output shows which step went wrong. A multiply count that is wrong shows up as a missing, early or extra result strobe when a chain reaches its cap. A restart flag that is ignored shows up as a result built from stale operands. The scoreboard checks every field of every result against a model that computes from the arithmetic rules.

// File: rtl/dnm_pkg.sv
package dnm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHAIN = 2'd1,
    ST_NORM  = 2'd2
  } dnm_state_e;
endpackage

// File: rtl/dnm_mant_mul.sv
module dnm_mant_mul #(
  parameter int ACC_W  = 20,
  parameter int MANT_W = 16
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [MANT_W-1:0] opm,
  output logic [ACC_W-1:0]  prod_hi
);
  localparam int PW = ACC_W + MANT_W;

  logic [PW-1:0] prod_full;

  always_comb begin
    prod_full = {{MANT_W{1'b0}}, acc} * {{ACC_W{1'b0}}, opm};
    // keep the top ACC_W bits; the product's 2 integer bits are absorbed by +1 on the exponent
    prod_hi   = ACC_W'(prod_full >> MANT_W);
  end
endmodule

// File: rtl/dnm_lzc.sv
module dnm_lzc #(
  parameter int W    = 20,
  parameter int LZ_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    vec,
  output logic [LZ_W-1:0] lz
);
  always_comb begin
    logic hit;
    hit = 1'b0;
    lz  = LZ_W'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && vec[i]) begin
        lz  = LZ_W'(W - 1 - i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dnm_normalize.sv
module dnm_normalize #(
  parameter int ACC_W   = 20,
  parameter int GUARD_W = 4,
  parameter int EXP_W   = 10,
  parameter int LZ_W    = $clog2(ACC_W + 1)
) (
  input  logic [ACC_W-1:0]         mant,
  input  logic [EXP_W-1:0]         exp_in,
  output logic [ACC_W-GUARD_W-2:0] frac,
  output logic [EXP_W-1:0]         exp_out,
  output logic [LZ_W-1:0]          lz,
  output logic                     lead_bit
);
  localparam int FRAC_W = ACC_W - GUARD_W - 1;

  logic [ACC_W-1:0] shifted;

  dnm_lzc #(.W(ACC_W), .LZ_W(LZ_W)) u_lzc (
    .vec (mant),
    .lz  (lz)
  );

  always_comb begin
    shifted  = mant << lz;
    lead_bit = shifted[ACC_W-1];
    frac     = FRAC_W'(shifted >> GUARD_W);
    exp_out  = exp_in - EXP_W'(lz);
  end
endmodule

// File: rtl/dnm_chain_top.sv
module dnm_chain_top #(
  parameter int MANT_W   = 16,
  parameter int EXP_W    = 10,
  parameter int GUARD_W  = 4,
  parameter int MAX_MULS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic                     in_sign,
  input  logic [EXP_W-1:0]         in_exp,
  input  logic [MANT_W-2:0]        in_frac,
  output logic                     out_valid,
  output logic                     out_sign,
  output logic [EXP_W-1:0]         out_exp,
  output logic [MANT_W-2:0]        out_frac,
  output logic [MANT_W+GUARD_W-1:0] out_raw_mant,
  output logic [EXP_W-1:0]         out_raw_exp
);
  import dnm_pkg::*;

  localparam int FRAC_W = MANT_W - 1;
  localparam int ACC_W  = MANT_W + GUARD_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int CNT_W  = $clog2(MAX_MULS + 1);
  localparam int LZ_W   = $clog2(ACC_W + 1);

  dnm_state_e       st_q;
  logic [ACC_W-1:0] acc_mant;
  logic [EXP_W-1:0] acc_exp;
  logic             acc_sign;
  logic [CNT_W-1:0] mul_cnt;

  logic [MANT_W-1:0] op_mant;
  logic [ACC_W-1:0]  mul_mant;
  logic [EXP_W-1:0]  mul_exp;
  logic              full;
  logic              take;

  logic [FRAC_W-1:0] nrm_frac;
  logic [EXP_W-1:0]  nrm_exp;
  logic [LZ_W-1:0]   nrm_lz;
  logic              nrm_lead;

  assign op_mant  = {1'b1, in_frac};
  assign full     = (mul_cnt == CNT_W'(MAX_MULS));
  assign in_ready = (st_q == ST_IDLE) || ((st_q == ST_CHAIN) && !full);
  assign take     = in_valid && in_ready;
  assign mul_exp  = acc_exp + in_exp - EXP_W'(BIAS) + EXP_W'(1);

  dnm_mant_mul #(.ACC_W(ACC_W), .MANT_W(MANT_W)) u_mul (
    .acc     (acc_mant),
    .opm     (op_mant),
    .prod_hi (mul_mant)
  );

  dnm_normalize #(
    .ACC_W(ACC_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W), .LZ_W(LZ_W)
  ) u_norm (
    .mant     (acc_mant),
    .exp_in   (acc_exp),
    .frac     (nrm_frac),
    .exp_out  (nrm_exp),
    .lz       (nrm_lz),
    .lead_bit (nrm_lead)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      acc_mant     <= '0;
      acc_exp      <= '0;
      acc_sign     <= 1'b0;
      mul_cnt      <= '0;
      out_valid    <= 1'b0;
      out_sign     <= 1'b0;
      out_exp      <= '0;
      out_frac     <= '0;
      out_raw_mant <= '0;
      out_raw_exp  <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE, ST_CHAIN: begin
          if (take) begin
            if (st_q == ST_IDLE || in_first) begin
              acc_mant <= {op_mant, {GUARD_W{1'b0}}};
              acc_exp  <= in_exp;
              acc_sign <= in_sign;
              mul_cnt  <= '0;
            end else begin
              acc_mant <= mul_mant;
              acc_exp  <= mul_exp;
              acc_sign <= acc_sign ^ in_sign;
              mul_cnt  <= mul_cnt + CNT_W'(1);
            end
            st_q <= in_last ? ST_NORM : ST_CHAIN;
          end else if (st_q == ST_CHAIN && full && in_valid) begin
            st_q <= ST_NORM;
          end
        end
        ST_NORM: begin
          out_valid    <= 1'b1;
          out_sign     <= acc_sign;
          out_exp      <= nrm_exp;
          out_frac     <= nrm_frac;
          out_raw_mant <= acc_mant;
          out_raw_exp  <= acc_exp;
          mul_cnt      <= '0;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7: a closing operand yields the result strobe two edges later
  a_r7_result_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |-> ##2 out_valid);

  // R7: the result strobe lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5: leading zeros never exceed the multiplies performed
  a_r5_slip_bound: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORM) |-> (int'(nrm_lz) <= int'(mul_cnt)));

  // R6: the shifter always brings a one into the top position
  a_r6_lead_one: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORM) |-> nrm_lead);

  // R9: the multiply count stays within the cap
  a_r9_count_cap: assert property (@(posedge clk) disable iff (rst)
    int'(mul_cnt) <= MAX_MULS);

  // R9: an operand meeting a full chain forces normalization next
  a_r9_forced_norm: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CHAIN && full && in_valid) |=> (st_q == ST_NORM));
endmodule

// File: tb/tb_dnm_chain_top.sv
module tb_dnm_chain_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_first, in_last, in_sign;
  logic [9:0]  in_exp;
  logic [14:0] in_frac;
  logic        out_valid, out_sign;
  logic [9:0]  out_exp, out_raw_exp;
  logic [14:0] out_frac;
  logic [19:0] out_raw_mant;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [55:0] exp_q[$];
  string       tag_q[$];

  // model state
  logic [63:0] m_acc;
  int          m_exp;
  logic        m_sign;
  int          m_cnt;
  bit          m_active = 0;

  always #2 clk = ~clk;

  dnm_chain_top dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last),
    .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
    .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_frac(out_frac),
    .out_raw_mant(out_raw_mant), .out_raw_exp(out_raw_exp)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [55:0] expect_of();
    int lz = 0;
    logic [63:0] nrm;
    int ex;
    for (int i = 19; i >= 0; i--) begin
      if (m_acc[i]) break;
      lz++;
    end
    nrm = (m_acc << lz) & 64'hFFFFF;
    ex  = (m_exp - lz) & 1023;
    return {m_sign, ex[9:0], nrm[18:4], m_acc[19:0], m_exp[9:0]};
  endfunction

  task automatic push_result(string tag);
    exp_q.push_back(expect_of());
    tag_q.push_back(tag);
    m_active = 0;
  endtask

  // driver: called at a falling edge, returns at the falling edge after the operand is taken
  task automatic send_op(bit s, int e, int f, bit first, bit last, string tag);
    if (m_active && m_cnt == 4) push_result({tag, " R9 forced"});
    if (!m_active || first) begin
      m_acc = {44'd0, 1'b1, f[14:0], 4'b0000};
      m_exp = e;
      m_sign = s;
      m_cnt = 0;
      m_active = 1;
    end else begin
      m_acc = (m_acc * {48'd0, 1'b1, f[14:0]}) >> 16;
      m_exp = (m_exp + e - 511 + 1) & 1023;
      m_sign = m_sign ^ s;
      m_cnt++;
    end
    if (last) push_result(tag);
    in_valid = 1; in_sign = s; in_exp = e[9:0]; in_frac = f[14:0];
    in_first = first; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        logic [55:0] act;
        act = {out_sign, out_exp, out_frac, out_raw_mant, out_raw_exp};
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected result", {8'd0, act}, 64'd0);
        end else begin
          logic [55:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(act == e, t, {8'd0, act}, {8'd0, e});
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1; in_valid = 0; in_first = 0; in_last = 0;
    in_sign = 0; in_exp = 0; in_frac = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    // R3 single operand passes through unchanged
    send_op(1, 600, 15'h1234, 1, 1, "R3 single operand");
    repeat (2) @(negedge clk);

    // R4 R6 R8 1.5 * -1.5, with latency check R7
    send_op(0, 511, 15'h4000, 1, 0, "R4 first");
    send_op(1, 511, 15'h4000, 0, 1, "R4 R6 R8 1.5x-1.5");
    check(in_ready == 0, "R7 ready low during normalization", in_ready, 0);
    @(negedge clk);
    check(out_valid == 1, "R7 result strobe", out_valid, 1);
    check(in_ready == 1, "R7 ready restored", in_ready, 1);
    @(negedge clk);
    check(out_valid == 0, "R7 strobe single cycle", out_valid, 0);

    // R5 four multiplies of 1.0: raw mantissa 0x08000
    send_op(0, 511, 0, 1, 0, "R5");
    for (int i = 0; i < 3; i++) send_op(0, 511, 0, 0, 0, "R5");
    send_op(0, 511, 0, 0, 1, "R5 four slips");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 drained", exp_q.size(), 0);

    // R4 maximal mantissas
    send_op(1, 505, 15'h7FFF, 1, 0, "R4");
    for (int i = 0; i < 3; i++) send_op(1, 515, 15'h7FFF, 0, 0, "R4");
    send_op(0, 500, 15'h7FFF, 0, 1, "R4 R8 max mantissas");
    repeat (2) @(negedge clk);

    // R9 R11 full chain forces normalization
    send_op(0, 510, 15'h2AAA, 1, 0, "R9");
    for (int i = 0; i < 4; i++) send_op(0, 512, 15'h1555 + i, 0, 0, "R9");
    check(in_ready == 0, "R11 ready low when chain full", in_ready, 0);
    send_op(1, 520, 15'h0F0F, 0, 1, "R9 new chain after force");
    repeat (3) @(negedge clk);

    // R10 restart mid-chain
    send_op(0, 530, 15'h7000, 1, 0, "R10");
    send_op(1, 490, 15'h0123, 0, 0, "R10");
    send_op(0, 505, 15'h3333, 1, 0, "R10");
    send_op(1, 515, 15'h5555, 0, 1, "R10 restart discards");
    repeat (3) @(negedge clk);

    // R2 R4 R6 R8 varied chains
    for (int c = 0; c < 24; c++) begin
      int len;
      len = 1 + (c % 5);
      for (int k = 0; k < len; k++) begin
        send_op($urandom_range(0, 1), $urandom_range(500, 522), $urandom_range(0, 32767),
                (k == 0), (k == len - 1), "R2 R4 R6 R8 varied chain");
      end
      if (c % 3 == 0) repeat (2) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule